// File: doc/BRIEF.md
# Linked Parameter-Set DMA Address Sequencer

This block sequences the addresses of a single DMA channel. Software fills a small table of parameter sets. Each set describes a three-level transfer:

- an element of A bytes,
- a frame of B elements,
- a block of C frames.

The set also carries separate signed strides for the source side and the destination side. After the channel is started on one set, each pulse of the peripheral's sync event releases work. In element-sync mode a pulse releases one element. In frame-sync mode it releases one whole frame. For every element the block emits one source address, one destination address and the byte count.

When the last element of a set has been emitted, the set named by its link field is copied into the working registers and the walk continues. A link of all ones ends the chain. A set can request a one-cycle completion pulse. A stride of zero pins one side to a fixed address, which suits a peripheral FIFO, while the memory side walks through a buffer. Events that arrive while earlier work is still being emitted are counted and served in order. An event that arrives while no set is active is flagged. A stop input abandons the active set without a completion pulse.

Top module: `dma_seq_top`

## Requirements
- R1: The table is written one 32-bit word per cycle, addressed by set index and word select. The word select codes are:
  - 0: options. Bit 0 selects frame-sync mode; bit 1 enables the completion pulse.
  - 1: source address.
  - 2: destination address.
  - 3: counts. B is in bits 31:16 and A is in bits 15:0.
  - 4: C count, in bits 15:0.
  - 5: element strides. Destination is in bits 31:16 and source is in bits 15:0.
  - 6: frame strides, in the same packing as word 5.
  - 7: link. The B reload is in bits 31:16 and the link index is in bits 15:0.
- R2: After reset, chan_active, xfer_valid, done_irq and evt_err are low. A go pulse copies the chosen set into the working registers and raises chan_active at the next edge.
- R3: In element-sync mode, one sync event yields exactly one element. The first element of a quiet channel is valid in the cycle after the second rising edge following the event.
- R4: In frame-sync mode, one sync event yields the current frame's remaining elements, one per cycle with no gap.
- R5: Within a frame, each following element's source and destination addresses are the previous ones plus the sign-extended element strides. xfer_bytes carries A.
- R6: At a frame boundary, the addresses become the previous frame's start plus the sign-extended frame strides. The new frame's length is the B reload field, not the B count.
- R7: A side whose strides are both zero keeps the same address for every element of the set.
- R8: When a set ends, the set named by its link index is loaded and continues on later events. A link of 0xFFFF drops chan_active and discards any surplus events.
- R9: done_irq pulses for one cycle, right after the last element of a set, only if that set enables it.
- R10: Sync events that arrive while work is being emitted are counted and all served in order. No element is lost.
- R11: A sync event while chan_active is low produces no element and pulses evt_err one cycle later.
- R12: stop drops chan_active at the next edge, ends emission, discards pending events and suppresses done_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table word write enable |
| tbl_set | input | IDX_W | Set index for the write |
| tbl_word | input | 3 | Word select within the set |
| tbl_data | input | 32 | Data written to the table |
| go | input | 1 | Load set go_set and activate the channel |
| go_set | input | IDX_W | First set of the chain |
| stop | input | 1 | Abandon the active set |
| sync_evt | input | 1 | Peripheral sync event |
| xfer_valid | output | 1 | An element address pair is presented |
| xfer_src | output | 32 | Source byte address of the element |
| xfer_dst | output | 32 | Destination byte address of the element |
| xfer_bytes | output | 16 | Bytes in the element (A) |
| done_irq | output | 1 | Completion pulse |
| evt_err | output | 1 | Event arrived with no active set |
| chan_active | output | 1 | A set is loaded and running |

## Verification
Several rules are checked on every cycle by properties:
- no element appears while the channel is idle;
- a completion pulse always follows an emitted element;
- an error pulse always traces back to an event on an idle channel;
- a stop leaves the channel silent and without a pulse on the next cycle;
- the pending event count never sits at its ceiling when a new event arrives.

The exact address sequences, frame lengths after reload, link order, event latency and the contiguity of frame bursts are only visible through the bench's scenarios. These scenarios include a sweep over both sync modes and small B and C counts, and they compare every emitted element against arithmetic expectations.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int WORD_W        = 32;
    localparam int WORDS_PER_SET = 8;
    localparam logic [15:0] LINK_END = 16'hFFFF;

    typedef enum logic [2:0] {
        W_OPT   = 3'd0,
        W_SRC   = 3'd1,
        W_DST   = 3'd2,
        W_CNT   = 3'd3,
        W_CCNT  = 3'd4,
        W_ESTR  = 3'd5,
        W_FSTR  = 3'd6,
        W_LINK  = 3'd7
    } word_sel_e;

    typedef struct packed {
        logic        frame_sync;
        logic        irq_en;
        logic [31:0] src;
        logic [31:0] dst;
        logic [15:0] acnt;
        logic [15:0] bcnt;
        logic [15:0] ccnt;
        logic [15:0] src_estr;
        logic [15:0] dst_estr;
        logic [15:0] src_fstr;
        logic [15:0] dst_fstr;
        logic [15:0] brld;
        logic [15:0] link;
    } pset_t;

    typedef struct packed {
        pset_t       cfg;
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] fsrc;
        logic [31:0] fdst;
        logic [15:0] bleft;
        logic [15:0] cleft;
    } walk_t;

    function automatic logic [31:0] pick(input logic [WORDS_PER_SET*WORD_W-1:0] f,
                                         input word_sel_e w);
        return f[int'(w)*WORD_W +: WORD_W];
    endfunction

    function automatic pset_t unpack_set(input logic [WORDS_PER_SET*WORD_W-1:0] f);
        pset_t p;
        logic [31:0] opt;
        opt          = pick(f, W_OPT);
        p.frame_sync = opt[0];
        p.irq_en     = opt[1];
        p.src        = pick(f, W_SRC);
        p.dst        = pick(f, W_DST);
        p.acnt       = pick(f, W_CNT)[15:0];
        p.bcnt       = pick(f, W_CNT)[31:16];
        p.ccnt       = pick(f, W_CCNT)[15:0];
        p.src_estr   = pick(f, W_ESTR)[15:0];
        p.dst_estr   = pick(f, W_ESTR)[31:16];
        p.src_fstr   = pick(f, W_FSTR)[15:0];
        p.dst_fstr   = pick(f, W_FSTR)[31:16];
        p.link       = pick(f, W_LINK)[15:0];
        p.brld       = pick(f, W_LINK)[31:16];
        return p;
    endfunction

    function automatic logic [31:0] add_stride(input logic [31:0] a, input logic [15:0] s);
        return a + {{16{s[15]}}, s};
    endfunction

    function automatic walk_t walk_load(input pset_t p);
        walk_t w;
        w.cfg   = p;
        w.src   = p.src;
        w.dst   = p.dst;
        w.fsrc  = p.src;
        w.fdst  = p.dst;
        w.bleft = p.bcnt;
        w.cleft = p.ccnt;
        return w;
    endfunction

    // Advance past one element that is not the last of its set.
    function automatic walk_t walk_step(input walk_t w);
        walk_t n;
        n = w;
        if (w.bleft > 16'd1) begin
            n.src   = add_stride(w.src, w.cfg.src_estr);
            n.dst   = add_stride(w.dst, w.cfg.dst_estr);
            n.bleft = w.bleft - 16'd1;
        end else begin
            n.fsrc  = add_stride(w.fsrc, w.cfg.src_fstr);
            n.fdst  = add_stride(w.fdst, w.cfg.dst_fstr);
            n.src   = n.fsrc;
            n.dst   = n.fdst;
            n.bleft = w.cfg.brld;
            n.cleft = w.cleft - 16'd1;
        end
        return n;
    endfunction

endpackage

// File: rtl/dma_param_table.sv
module dma_param_table
    import dma_seq_pkg::*;
#(
    parameter int NSETS = 8,
    parameter int IDX_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_set,
    input  logic [2:0]       wr_word,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output pset_t            rd_set
);
    localparam int FLAT_W = WORDS_PER_SET * WORD_W;

    logic [WORD_W-1:0] mem [NSETS][WORDS_PER_SET];
    logic [FLAT_W-1:0] flat;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++)
                for (int w = 0; w < WORDS_PER_SET; w++)
                    mem[s][w] <= '0;
        end else if (we) begin
            mem[wr_set][wr_word] <= wr_data;
        end
    end

    always_comb begin
        for (int w = 0; w < WORDS_PER_SET; w++)
            flat[w*WORD_W +: WORD_W] = mem[rd_idx][w];
    end

    assign rd_set = unpack_set(flat);

endmodule

// File: rtl/dma_evt_track.sv
module dma_evt_track #(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  logic              chan_on,
    input  logic              take,
    input  logic              flush,
    output logic              have_evt,
    output logic              err,
    output logic [PEND_W-1:0] pend
);
    logic [PEND_W-1:0] inc;
    logic [PEND_W-1:0] dec;

    assign inc      = {{(PEND_W-1){1'b0}}, evt && chan_on};
    assign dec      = {{(PEND_W-1){1'b0}}, take};
    assign have_evt = (pend != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            err  <= 1'b0;
        end else begin
            err  <= evt && !chan_on;
            pend <= flush ? '0 : (pend + inc - dec);
        end
    end

endmodule

// File: rtl/dma_addr_walk.sv
module dma_addr_walk
    import dma_seq_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [IDX_W-1:0] go_set,
    input  logic             stop,
    input  logic             have_evt,
    input  pset_t            tbl_set,
    output logic [IDX_W-1:0] rd_idx,
    output logic             take,
    output logic             flush,
    output logic             chan_on,
    output logic             emit,
    output logic [31:0]      out_src,
    output logic [31:0]      out_dst,
    output logic [15:0]      out_bytes,
    output logic             irq
);
    walk_t       st;
    logic [15:0] run;
    logic        frame_end;
    logic        set_end;
    logic        chain_end;

    assign emit      = chan_on && (run != 16'd0);
    assign frame_end = emit && (st.bleft <= 16'd1);
    assign set_end   = frame_end && (st.cleft <= 16'd1);
    assign chain_end = set_end && (st.cfg.link == LINK_END);
    assign take      = chan_on && (run == 16'd0) && have_evt && !go && !stop;
    assign rd_idx    = go ? go_set : st.cfg.link[IDX_W-1:0];
    assign flush     = stop || (chain_end && !go);

    assign out_src   = st.src;
    assign out_dst   = st.dst;
    assign out_bytes = st.cfg.acnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            run     <= '0;
            chan_on <= 1'b0;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (stop) begin
                chan_on <= 1'b0;
                run     <= '0;
            end else if (go) begin
                chan_on <= 1'b1;
                run     <= '0;
                st      <= walk_load(tbl_set);
            end else if (take) begin
                run <= st.cfg.frame_sync ? st.bleft : 16'd1;
            end else if (emit) begin
                run <= run - 16'd1;
                if (set_end) begin
                    irq <= st.cfg.irq_en;
                    if (chain_end) chan_on <= 1'b0;
                    else           st      <= walk_load(tbl_set);
                end else begin
                    st <= walk_step(st);
                end
            end
        end
    end

endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
    import dma_seq_pkg::*;
#(
    parameter int NSETS  = 8,
    parameter int PEND_W = 4,
    parameter int IDX_W  = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_set,
    input  logic [2:0]       tbl_word,
    input  logic [31:0]      tbl_data,
    input  logic             go,
    input  logic [IDX_W-1:0] go_set,
    input  logic             stop,
    input  logic             sync_evt,
    output logic             xfer_valid,
    output logic [31:0]      xfer_src,
    output logic [31:0]      xfer_dst,
    output logic [15:0]      xfer_bytes,
    output logic             done_irq,
    output logic             evt_err,
    output logic             chan_active
);
    pset_t             rd_set;
    logic [IDX_W-1:0]  rd_idx;
    logic              take;
    logic              flush;
    logic              have_evt;
    logic [PEND_W-1:0] pend_cnt;

    dma_param_table #(.NSETS(NSETS), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst(rst), .we(tbl_we), .wr_set(tbl_set), .wr_word(tbl_word),
        .wr_data(tbl_data), .rd_idx(rd_idx), .rd_set(rd_set)
    );

    dma_evt_track #(.PEND_W(PEND_W)) u_evt (
        .clk(clk), .rst(rst), .evt(sync_evt), .chan_on(chan_active), .take(take),
        .flush(flush), .have_evt(have_evt), .err(evt_err), .pend(pend_cnt)
    );

    dma_addr_walk #(.IDX_W(IDX_W)) u_walk (
        .clk(clk), .rst(rst), .go(go), .go_set(go_set), .stop(stop),
        .have_evt(have_evt), .tbl_set(rd_set), .rd_idx(rd_idx), .take(take),
        .flush(flush), .chan_on(chan_active), .emit(xfer_valid),
        .out_src(xfer_src), .out_dst(xfer_dst), .out_bytes(xfer_bytes), .irq(done_irq)
    );

endmodule

// File: rtl/dma_seq_checker.sv
module dma_seq_checker #(
    parameter int PEND_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              stop,
    input logic              sync_evt,
    input logic              xfer_valid,
    input logic              done_irq,
    input logic              evt_err,
    input logic              chan_active,
    input logic [PEND_W-1:0] pend
);
    // R2: an idle channel emits nothing
    a_r2_idle_silent: assert property (@(posedge clk) disable iff (rst)
        !chan_active |-> !xfer_valid);

    // R9: a completion pulse always follows an emitted element
    a_r9_irq_after_elem: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> $past(xfer_valid));

    // R11: an error pulse traces back to an event on an idle channel
    a_r11_err_cause: assert property (@(posedge clk) disable iff (rst)
        evt_err |-> $past(sync_evt && !chan_active));

    // R12: after stop the channel is idle, silent and raises no pulse
    a_r12_stop_quiet: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!xfer_valid && !done_irq && !chan_active));

    // R10: an accepted event never meets a full pending counter
    a_r10_no_drop: assert property (@(posedge clk) disable iff (rst)
        (sync_evt && chan_active && !stop) |-> (pend != {PEND_W{1'b1}}));

endmodule

bind dma_seq_top dma_seq_checker #(.PEND_W(PEND_W)) u_chk (
    .clk(clk), .rst(rst), .stop(stop), .sync_evt(sync_evt), .xfer_valid(xfer_valid),
    .done_irq(done_irq), .evt_err(evt_err), .chan_active(chan_active), .pend(pend_cnt)
);

// File: tb/dma_seq_top_bench.sv
module dma_seq_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_set = '0;
    logic [2:0]  tbl_word = '0;
    logic [31:0] tbl_data = '0;
    logic        go = 1'b0;
    logic [2:0]  go_set = '0;
    logic        stop = 1'b0;
    logic        sync_evt = 1'b0;
    logic        xfer_valid;
    logic [31:0] xfer_src;
    logic [31:0] xfer_dst;
    logic [15:0] xfer_bytes;
    logic        done_irq;
    logic        evt_err;
    logic        chan_active;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    int err_cnt = 0;
    int val_cnt = 0;
    bit loose = 1'b0;

    logic [31:0] q_src[$];
    logic [31:0] q_dst[$];
    logic [15:0] q_bytes[$];
    int          q_tag[$];

    always #5 clk = ~clk;

    dma_seq_top u_dma_seq_top (
        .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_set(tbl_set), .tbl_word(tbl_word),
        .tbl_data(tbl_data), .go(go), .go_set(go_set), .stop(stop), .sync_evt(sync_evt),
        .xfer_valid(xfer_valid), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .xfer_bytes(xfer_bytes), .done_irq(done_irq), .evt_err(evt_err),
        .chan_active(chan_active)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Element monitor: compares each emitted element against the expected stream.
    always @(negedge clk) begin
        if (!rst) begin
            if (done_irq) irq_cnt++;
            if (evt_err)  err_cnt++;
            if (xfer_valid) begin
                val_cnt++;
                if (!loose) begin
                    if (q_src.size() == 0) begin
                        chk(1'b0, "R10 unexpected element", xfer_src, 32'hFFFF_FFFF);
                    end else begin
                        chk(xfer_src == q_src[0],
                            $sformatf("R%0d element src", q_tag[0]), xfer_src, q_src[0]);
                        chk(xfer_dst == q_dst[0],
                            $sformatf("R%0d element dst", q_tag[0]), xfer_dst, q_dst[0]);
                        chk(xfer_bytes == q_bytes[0], "R5 element bytes",
                            {16'd0, xfer_bytes}, {16'd0, q_bytes[0]});
                        void'(q_src.pop_front());
                        void'(q_dst.pop_front());
                        void'(q_bytes.pop_front());
                        void'(q_tag.pop_front());
                    end
                end
            end
        end
    end

    task automatic put_word(input int s, input int w, input logic [31:0] d);
        tbl_we = 1'b1; tbl_set = 3'(s); tbl_word = 3'(w); tbl_data = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // R1 word layout
    task automatic write_set(input int s, input bit fsync, input bit irqen,
                             input logic [31:0] src, input logic [31:0] dst,
                             input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                             input logic [15:0] sb, input logic [15:0] db,
                             input logic [15:0] sc, input logic [15:0] dc,
                             input logic [15:0] brld, input logic [15:0] link);
        put_word(s, 0, {30'd0, irqen, fsync});
        put_word(s, 1, src);
        put_word(s, 2, dst);
        put_word(s, 3, {b, a});
        put_word(s, 4, {16'd0, c});
        put_word(s, 5, {db, sb});
        put_word(s, 6, {dc, sc});
        put_word(s, 7, {brld, link});
    endtask

    task automatic expect_set(input logic [31:0] src, input logic [31:0] dst,
                              input logic [15:0] a, input int b, input int c,
                              input logic [15:0] sb, input logic [15:0] db,
                              input logic [15:0] sc, input logic [15:0] dc, input int brld);
        for (int cf = 0; cf < c; cf++) begin
            int nb;
            logic [31:0] fs;
            logic [31:0] fd;
            nb = (cf == 0) ? b : brld;
            fs = src + 32'(cf) * {{16{sc[15]}}, sc};
            fd = dst + 32'(cf) * {{16{dc[15]}}, dc};
            for (int j = 0; j < nb; j++) begin
                q_src.push_back(fs + 32'(j) * {{16{sb[15]}}, sb});
                q_dst.push_back(fd + 32'(j) * {{16{db[15]}}, db});
                q_bytes.push_back(a);
                if ((sb == 16'd0 && sc == 16'd0) || (db == 16'd0 && dc == 16'd0))
                    q_tag.push_back(7);          // R7 fixed side
                else if (cf > 0 && j == 0)
                    q_tag.push_back(6);          // R6 frame boundary
                else
                    q_tag.push_back(5);          // R5 element stride
            end
        end
    endtask

    task automatic start(input int s);
        go = 1'b1; go_set = 3'(s);
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic events(input int n);
        for (int i = 0; i < n; i++) begin
            sync_evt = 1'b1;
            @(negedge clk);
        end
        sync_evt = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired got=%0d exp=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int irq0;
        int first;
        int last;
        int seen;
        int v0;
        int e0;

        idle(3);
        rst = 1'b0;
        idle(1);
        // R2 reset state
        chk(!chan_active, "R2 reset chan_active", {31'd0, chan_active}, 0);
        chk(!xfer_valid && !done_irq && !evt_err, "R2 reset outputs",
            {29'd0, xfer_valid, done_irq, evt_err}, 0);

        // Element-sync, memory to fixed FIFO, two frames of three
        write_set(0, 1'b0, 1'b1, 32'h1000, 32'h8000, 16'd4, 16'd3, 16'd2,
                  16'd4, 16'd0, 16'd12, 16'd0, 16'd3, 16'hFFFF);
        expect_set(32'h1000, 32'h8000, 16'd4, 3, 2, 16'd4, 16'd0, 16'd12, 16'd0, 3);
        start(0);
        chk(chan_active, "R2 go activates", {31'd0, chan_active}, 1);
        sync_evt = 1'b1;
        @(negedge clk);
        sync_evt = 1'b0;
        chk(!xfer_valid, "R3 no element one edge after event", {31'd0, xfer_valid}, 0);
        @(negedge clk);
        chk(xfer_valid, "R3 element two edges after event", {31'd0, xfer_valid}, 1);
        @(negedge clk);
        chk(!xfer_valid, "R3 single element per event", {31'd0, xfer_valid}, 0);
        events(5);
        idle(20);
        chk(q_src.size() == 0, "R10 all element-sync events served", q_src.size(), 0);
        chk(irq_cnt == 1, "R9 one completion pulse", irq_cnt, 1);
        chk(!chan_active, "R8 all-ones link ends chain", {31'd0, chan_active}, 0);

        // Frame-sync chain: set1 (no pulse) links to set2 (pulse, reload differs)
        write_set(1, 1'b1, 1'b0, 32'h40, 32'h2000, 16'd2, 16'd4, 16'd2,
                  16'd0, 16'd2, 16'd0, 16'd8, 16'd4, 16'd2);
        write_set(2, 1'b1, 1'b1, 32'h100, 32'h3000, 16'd1, 16'd2, 16'd3,
                  16'd1, 16'd1, 16'hFFF0, 16'd4, 16'd3, 16'hFFFF);
        expect_set(32'h40, 32'h2000, 16'd2, 4, 2, 16'd0, 16'd2, 16'd0, 16'd8, 4);
        expect_set(32'h100, 32'h3000, 16'd1, 2, 3, 16'd1, 16'd1, 16'hFFF0, 16'd4, 3);
        irq0 = irq_cnt;
        start(1);
        events(1);
        first = -1; last = -1; seen = 0;
        for (int i = 0; i < 8; i++) begin
            if (xfer_valid) begin
                if (first < 0) first = i;
                last = i;
                seen++;
            end
            @(negedge clk);
        end
        chk(seen == 4, "R4 frame event yields B elements", seen, 4);
        chk(last - first + 1 == 4, "R4 frame elements contiguous", last - first + 1, 4);
        chk(irq_cnt == irq0, "R9 no pulse when disabled", irq_cnt, irq0);
        events(4);
        idle(30);
        chk(q_src.size() == 0, "R8 linked set served", q_src.size(), 0);
        chk(irq_cnt == irq0 + 1, "R9 pulse only on final set", irq_cnt, irq0 + 1);
        chk(!chan_active, "R8 chain ended", {31'd0, chan_active}, 0);

        // Event with no active set
        e0 = err_cnt; v0 = val_cnt;
        events(1);
        idle(3);
        chk(err_cnt == e0 + 1, "R11 error pulse", err_cnt, e0 + 1);
        chk(val_cnt == v0, "R11 no element", val_cnt, v0);

        // Stop during a run
        write_set(3, 1'b0, 1'b1, 32'h500, 32'h600, 16'd1, 16'd4, 16'd1,
                  16'd1, 16'd1, 16'd0, 16'd0, 16'd4, 16'hFFFF);
        loose = 1'b1;
        irq0 = irq_cnt;
        start(3);
        events(4);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(!chan_active, "R12 stop deactivates", {31'd0, chan_active}, 0);
        v0 = val_cnt;
        idle(10);
        chk(val_cnt == v0, "R12 no element after stop", val_cnt, v0);
        chk(irq_cnt == irq0, "R12 no pulse after stop", irq_cnt, irq0);
        e0 = err_cnt;
        events(1);
        idle(3);
        chk(err_cnt == e0 + 1, "R12 pending discarded, channel idle", err_cnt, e0 + 1);
        loose = 1'b0;

        // Sweep over both modes and small B, C
        for (int m = 0; m < 2; m++) begin
            for (int b = 1; b <= 3; b++) begin
                for (int c = 1; c <= 3; c++) begin
                    int k;
                    logic [15:0] sb;
                    k = m * 9 + (b - 1) * 3 + (c - 1);
                    sb = (m == 1) ? 16'd2 : 16'hFFFE;
                    write_set(k % 8, m[0], 1'b1, 32'h4000 + 32'(k) * 256,
                              32'hA000 + 32'(k) * 64, 16'(k + 1), 16'(b), 16'(c),
                              sb, 16'd1, 16'd16, 16'(b), 16'(b), 16'hFFFF);
                    expect_set(32'h4000 + 32'(k) * 256, 32'hA000 + 32'(k) * 64,
                               16'(k + 1), b, c, sb, 16'd1, 16'd16, 16'(b), b);
                    irq0 = irq_cnt;
                    start(k % 8);
                    events((m == 1) ? c : b * c);
                    idle(30);
                    chk(q_src.size() == 0, "R1 sweep set fully emitted", q_src.size(), 0);
                    chk(irq_cnt == irq0 + 1, "R9 sweep completion pulse", irq_cnt, irq0 + 1);
                    chk(!chan_active, "R8 sweep chain end", {31'd0, chan_active}, 0);
                end
            end
        end

        summary();
        $finish;
    end

endmodule